// File: doc/BRIEF.md
# Bus-Side Register Guard with Error Detection

This block is the bus-facing register front end of a peripheral controller. It accepts APB transfers and completes every one of them with no wait states. It holds a small register set: a control word, sticky error flags, sticky event flags and an event mask. Any offset that falls outside the 4 KB register window is refused and recorded. The block also checks byte-wise odd parity on the address and on the write data, and it can answer an out-of-range access with the APB slave-error response.

Eleven peripheral events arrive as single-cycle pulses. Each pulse latches into a sticky flag. The flags are masked one by one and then ORed into a single interrupt line.

Reset can come from a system reset, from a power-on reset, or from a self-clearing software reset bit in the control word. All three have the same effect.

Top module: `apb_guard_regs`

## Requirements
- R1: Asserting rst_sys or rst_por clears every register at the next rising edge. After that edge, irq, ctrl_en, pslverr and both error flags read 0.
- R2: The control word sits at offset 0x000: bit 0 is the controller enable (driven on ctrl_en), bit 1 is the slave-error enable, and bit 2 is the software reset. The event mask sits at offset 0x00C in bits 10:0. Both registers read back what was written, and pready is always 1.
- R3: An access phase whose paddr has any bit above bit 11 set is out of range. It sets the sticky decode-error flag, which is bit 0 of the error register at offset 0x004. A read of such an address returns 0, and a write to it changes no register.
- R4: During an out-of-range access phase, pslverr equals control bit 1. For every in-range access, pslverr is 0.
- R5: Parity is odd. paddr_par[k] covers paddr byte k, and pwdata_par[k] covers pwdata byte k: the byte's ones plus the parity bit must add up to an odd count. A bad address parity on any access, or a bad data parity on a write, sets the sticky parity flag (error register bit 1). Such a write changes no register, and such a read returns 0.
- R6: Writing 1 to a bit of the error register (0x004) or of the event register (0x008) clears that bit. Writing 0 leaves the bit as it is.
- R7: A pulse on evt_in[i] sets bit i of the event register (0x008, bits 10:0). When an event and a clear hit the same bit in the same cycle, the event wins.
- R8: irq is the OR, over the 11 bits, of each event bit ANDed with its mask bit.
- R9: A valid write with control bit 2 set requests a software reset. At the following rising edge every register clears, just as in R1. Control bit 2 always reads 0.
- R10: In-range offsets with no register behind them read 0, ignore writes, and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_sys | input | 1 | System reset, synchronous, active high |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 16 | APB byte address |
| paddr_par | input | 2 | Odd parity, one bit per address byte |
| pwdata | input | 32 | APB write data |
| pwdata_par | input | 4 | Odd parity, one bit per write-data byte |
| evt_in | input | 11 | Peripheral event pulses |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | APB slave-error response |
| irq | output | 1 | Merged masked interrupt |
| ctrl_en | output | 1 | Controller enable |

## Verification
The bench goes after these corner cases:
- Out-of-range reads and writes, with the slave-error enable both off and on. A design that ignored the enable, or that let an out-of-range write land in an aliased register, would show a wrong pslverr or a changed mask.
- Single-byte parity faults on the address and on the data. A design that checked only some bytes, used even parity, or still committed the write would leave a wrong register value or a missing parity flag.
- An event pulse that coincides with a write-one-to-clear of the same bit. A design with clear-wins ordering would lose the event and drop irq.
- The software reset bit, as well as the power-on reset applied on its own. A design that forgot either source, or whose software reset bit never cleared, would keep stale state or hold itself in reset.

// File: rtl/apb_guard_pkg.sv
package apb_guard_pkg;

    // Register window: 4 KB of byte offsets
    localparam int WIN_W = 12;

    localparam logic [WIN_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [WIN_W-1:0] OFS_ERR  = 12'h004;
    localparam logic [WIN_W-1:0] OFS_EVT  = 12'h008;
    localparam logic [WIN_W-1:0] OFS_MASK = 12'h00C;

    // Control word bit positions
    localparam int CB_EN     = 0;
    localparam int CB_SLVERR = 1;
    localparam int CB_SWRST  = 2;

    // Error register bit positions
    localparam int EB_DEC = 0;
    localparam int EB_PAR = 1;

    typedef struct packed {
        logic             out_of_range;  // access phase, offset beyond window
        logic             par_bad;       // access phase, parity mismatch
        logic             commit_wr;     // write that may update state
        logic             rd_ok;         // read that may return data
        logic [WIN_W-1:0] offset;
    } acc_info_t;

    typedef struct packed {
        logic slverr_en;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic par;
        logic dec;
    } err_t;

    // True when a byte and its parity bit carry an odd number of ones
    function automatic logic odd_ok(input logic [7:0] b, input logic p);
        return ^{b, p};
    endfunction

endpackage

// File: rtl/apb_guard_decode.sv
module apb_guard_decode
    import apb_guard_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [ADDR_W/8-1:0] paddr_par,
    input  logic [DATA_W-1:0]   pwdata,
    input  logic [DATA_W/8-1:0] pwdata_par,
    output acc_info_t           info
);

    localparam int AB = ADDR_W / 8;
    localparam int DB = DATA_W / 8;

    logic          access;
    logic          high_hit;
    logic          any_bad;
    logic [AB-1:0] a_bad;
    logic [DB-1:0] d_bad;

    assign access = psel & penable;

    // Byte-wise odd parity on the address
    for (genvar i = 0; i < AB; i++) begin : g_apar
        assign a_bad[i] = ~odd_ok(paddr[8*i +: 8], paddr_par[i]);
    end

    // Byte-wise odd parity on the write data
    for (genvar j = 0; j < DB; j++) begin : g_dpar
        assign d_bad[j] = ~odd_ok(pwdata[8*j +: 8], pwdata_par[j]);
    end

    assign high_hit = |paddr[ADDR_W-1:WIN_W];
    assign any_bad  = (|a_bad) | (pwrite & (|d_bad));

    always_comb begin
        info.out_of_range = access & high_hit;
        info.par_bad      = access & any_bad;
        info.commit_wr    = access &  pwrite & ~high_hit & ~any_bad;
        info.rd_ok        = access & ~pwrite & ~high_hit & ~any_bad;
        info.offset       = paddr[WIN_W-1:0];
    end

endmodule

// File: rtl/apb_guard_csr.sv
module apb_guard_csr
    import apb_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we_ctrl,
    input  logic       we_err,
    input  logic [2:0] wdata,
    input  logic       set_dec,
    input  logic       set_par,
    output ctrl_t      ctrl,
    output err_t       err,
    output logic       soft_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            err    <= '0;
            soft_q <= 1'b0;
        end else begin
            if (we_ctrl) begin
                ctrl.enable    <= wdata[CB_EN];
                ctrl.slverr_en <= wdata[CB_SLVERR];
            end
            // Software reset request lives for one cycle
            soft_q  <= we_ctrl & wdata[CB_SWRST];
            // Sticky flags: a new error outranks the clear
            err.dec <= set_dec | (err.dec & ~(we_err & wdata[EB_DEC]));
            err.par <= set_par | (err.par & ~(we_err & wdata[EB_PAR]));
        end
    end

endmodule

// File: rtl/apb_guard_evt.sv
module apb_guard_evt #(
    parameter int N_EVT = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] evt_in,
    input  logic             we_clr,
    input  logic             we_mask,
    input  logic [N_EVT-1:0] wdata,
    output logic [N_EVT-1:0] stat,
    output logic [N_EVT-1:0] mask,
    output logic             irq
);

    logic [N_EVT-1:0] hit;

    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        logic s_q;
        logic m_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= 1'b0;
                m_q <= 1'b0;
            end else begin
                // A fresh event is kept even when a clear arrives with it
                s_q <= evt_in[i] | (s_q & ~(we_clr & wdata[i]));
                if (we_mask) begin
                    m_q <= wdata[i];
                end
            end
        end

        assign stat[i] = s_q;
        assign mask[i] = m_q;
        assign hit[i]  = s_q & m_q;
    end

    assign irq = |hit;

endmodule

// File: rtl/apb_guard_regs.sv
module apb_guard_regs
    import apb_guard_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int N_EVT  = 11
) (
    input  logic                clk,
    input  logic                rst_sys,
    input  logic                rst_por,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [ADDR_W/8-1:0] paddr_par,
    input  logic [DATA_W-1:0]   pwdata,
    input  logic [DATA_W/8-1:0] pwdata_par,
    input  logic [N_EVT-1:0]    evt_in,
    output logic [DATA_W-1:0]   prdata,
    output logic                pready,
    output logic                pslverr,
    output logic                irq,
    output logic                ctrl_en
);

    acc_info_t        info;
    ctrl_t            ctrl;
    err_t             err;
    logic             soft_q;
    logic             rst_all;
    logic             we_ctrl;
    logic             we_err;
    logic             we_evt;
    logic             we_mask;
    logic [N_EVT-1:0] evt_stat;
    logic [N_EVT-1:0] evt_mask;
    logic [DATA_W-1:0] rd_mux;

    // Every reset source has the same effect
    assign rst_all = rst_sys | rst_por | soft_q;

    apb_guard_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .paddr_par  (paddr_par),
        .pwdata     (pwdata),
        .pwdata_par (pwdata_par),
        .info       (info)
    );

    assign we_ctrl = info.commit_wr & (info.offset == OFS_CTRL);
    assign we_err  = info.commit_wr & (info.offset == OFS_ERR);
    assign we_evt  = info.commit_wr & (info.offset == OFS_EVT);
    assign we_mask = info.commit_wr & (info.offset == OFS_MASK);

    apb_guard_csr u_csr (
        .clk     (clk),
        .rst     (rst_all),
        .we_ctrl (we_ctrl),
        .we_err  (we_err),
        .wdata   (pwdata[2:0]),
        .set_dec (info.out_of_range),
        .set_par (info.par_bad),
        .ctrl    (ctrl),
        .err     (err),
        .soft_q  (soft_q)
    );

    apb_guard_evt #(
        .N_EVT (N_EVT)
    ) u_evt (
        .clk     (clk),
        .rst     (rst_all),
        .evt_in  (evt_in),
        .we_clr  (we_evt),
        .we_mask (we_mask),
        .wdata   (pwdata[N_EVT-1:0]),
        .stat    (evt_stat),
        .mask    (evt_mask),
        .irq     (irq)
    );

    always_comb begin
        unique case (info.offset)
            OFS_CTRL: rd_mux = DATA_W'({ctrl.slverr_en, ctrl.enable});
            OFS_ERR:  rd_mux = DATA_W'({err.par, err.dec});
            OFS_EVT:  rd_mux = DATA_W'(evt_stat);
            OFS_MASK: rd_mux = DATA_W'(evt_mask);
            default:  rd_mux = '0;
        endcase
    end

    assign prdata  = info.rd_ok ? rd_mux : '0;
    assign pready  = 1'b1;
    assign pslverr = info.out_of_range & ctrl.slverr_en;
    assign ctrl_en = ctrl.enable;

endmodule

// File: rtl/apb_guard_sva.sv
module apb_guard_sva
    import apb_guard_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int N_EVT  = 11
) (
    input logic                clk,
    input logic                rst_sys,
    input logic                rst_por,
    input logic                soft_q,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic [ADDR_W-1:0]   paddr,
    input logic [ADDR_W/8-1:0] paddr_par,
    input logic [DATA_W-1:0]   prdata,
    input logic                pslverr,
    input logic                irq,
    input logic                ctrl_en,
    input logic                slv_en,
    input logic                err_dec,
    input logic                err_par,
    input logic [N_EVT-1:0]    evt_in,
    input logic [N_EVT-1:0]    evt_stat,
    input logic [N_EVT-1:0]    evt_mask
);

    logic acc;
    logic oor;
    logic abad;
    logic any_rst;

    assign acc     = psel & penable;
    assign oor     = |paddr[ADDR_W-1:WIN_W];
    assign any_rst = rst_sys | rst_por | soft_q;

    always_comb begin
        abad = 1'b0;
        for (int k = 0; k < ADDR_W/8; k++) begin
            if (!odd_ok(paddr[8*k +: 8], paddr_par[k])) abad = 1'b1;
        end
    end

    AST_RESET_QUIETS: assert property (@(posedge clk)
        any_rst |=> (!irq && !ctrl_en && !err_dec && !err_par)); // R1

    AST_DEC_FLAG_SET: assert property (@(posedge clk) disable iff (any_rst)
        (acc && oor) |=> err_dec); // R3

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (any_rst)
        (acc && oor && !pwrite) |-> (prdata == '0)); // R3

    AST_OOR_WRITE_INERT: assert property (@(posedge clk) disable iff (any_rst)
        (acc && oor && pwrite) |=> ($stable(evt_mask) && $stable(ctrl_en))); // R3

    AST_SLVERR_ENABLED: assert property (@(posedge clk) disable iff (any_rst)
        (acc && oor && slv_en) |-> pslverr); // R4

    AST_SLVERR_GATED: assert property (@(posedge clk) disable iff (any_rst)
        (!(acc && oor && slv_en)) |-> !pslverr); // R4

    AST_ADDR_PAR_FLAG: assert property (@(posedge clk) disable iff (any_rst)
        (acc && abad) |=> err_par); // R5

    AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (any_rst)
        (|evt_in) |=> ((evt_stat & $past(evt_in)) == $past(evt_in))); // R7

    AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (any_rst)
        ((evt_stat & evt_mask) == '0) |-> !irq); // R8

    AST_SWRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst_sys || rst_por)
        soft_q |=> !soft_q); // R9

endmodule

bind apb_guard_regs apb_guard_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_EVT  (N_EVT)
) u_sva (
    .clk       (clk),
    .rst_sys   (rst_sys),
    .rst_por   (rst_por),
    .soft_q    (soft_q),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .paddr_par (paddr_par),
    .prdata    (prdata),
    .pslverr   (pslverr),
    .irq       (irq),
    .ctrl_en   (ctrl_en),
    .slv_en    (ctrl.slverr_en),
    .err_dec   (err.dec),
    .err_par   (err.par),
    .evt_in    (evt_in),
    .evt_stat  (evt_stat),
    .evt_mask  (evt_mask)
);

// File: tb/tb_apb_guard_regs.sv
module tb_apb_guard_regs;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NE = 11;

    logic          clk = 1'b0;
    logic          rst_sys = 1'b1;
    logic          rst_por = 1'b1;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [1:0]    paddr_par = '1;
    logic [DW-1:0] pwdata = '0;
    logic [3:0]    pwdata_par = '1;
    logic [NE-1:0] evt_in = '0;
    logic [DW-1:0] prdata;
    logic          pready;
    logic          pslverr;
    logic          irq;
    logic          ctrl_en;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state
    int m_ctrl = 0;
    int m_err = 0;
    int m_evt = 0;
    int m_mask = 0;
    bit m_soft = 0;
    logic [NE-1:0] evt_during = '0;

    always #2.5 clk = ~clk;

    apb_guard_regs dut (
        .clk(clk), .rst_sys(rst_sys), .rst_por(rst_por),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .paddr_par(paddr_par),
        .pwdata(pwdata), .pwdata_par(pwdata_par),
        .evt_in(evt_in), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq(irq), .ctrl_en(ctrl_en)
    );

    function automatic logic [1:0] apar(input logic [AW-1:0] a);
        return {~^a[15:8], ~^a[7:0]};
    endfunction

    function automatic logic [3:0] dpar(input logic [DW-1:0] d);
        return {~^d[31:24], ~^d[23:16], ~^d[15:8], ~^d[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst_sys || rst_por || m_soft) begin
            m_ctrl = 0; m_err = 0; m_evt = 0; m_mask = 0; m_soft = 0;
        end else begin
            bit acc, oor, pbad, ok;
            int clr;
            acc  = psel && penable;
            oor  = paddr >= 16'h1000;
            pbad = (paddr_par != apar(paddr)) || (pwrite && (pwdata_par != dpar(pwdata)));
            ok   = acc && !oor && !pbad && pwrite;
            clr  = 0;
            m_soft = 0;
            if (acc && oor)  m_err = m_err | 1;
            if (acc && pbad) m_err = m_err | 2;
            if (ok) begin
                case (paddr)
                    16'h000: begin m_ctrl = pwdata & 3; m_soft = pwdata[2]; end
                    16'h004: m_err = m_err & ~(pwdata & 3);
                    16'h008: clr = pwdata & 16'h7FF;
                    16'h00C: m_mask = pwdata & 16'h7FF;
                    default: ;
                endcase
            end
            m_evt = (m_evt & ~clr) | evt_in;
        end
    end

    // Continuous comparison of the level outputs
    always @(negedge clk) begin
        #1;
        if (cyc > 0 && !done) begin
            check(irq == ((m_evt & m_mask) != 0), "R8 irq", irq, (m_evt & m_mask) != 0);
            check(ctrl_en == m_ctrl[0], "R2 ctrl_en", ctrl_en, m_ctrl[0]);
            check(pready == 1'b1, "R2 pready", pready, 1);
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int exp_rd(input logic [AW-1:0] a);
        case (a)
            16'h000: return m_ctrl;
            16'h004: return m_err;
            16'h008: return m_evt;
            16'h00C: return m_mask;
            default: return 0;
        endcase
    endfunction

    // One APB transfer, started right after a falling edge
    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit bad_a, input bit bad_d, input string req);
        bit oor, pb;
        int e;
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        paddr_par  = apar(a) ^ {1'b0, bad_a};
        pwdata_par = dpar(d) ^ {3'b0, bad_d};
        @(negedge clk);
        penable = 1;
        evt_in = evt_during;
        #1;
        oor = a >= 16'h1000;
        pb  = bad_a || (wr && bad_d);
        check(pslverr == (oor && m_ctrl[1]), {req, " pslverr"}, pslverr, oor && m_ctrl[1]);
        if (!wr) begin
            e = (oor || pb) ? 0 : exp_rd(a);
            check(prdata == DW'(e), {req, " prdata"}, prdata, e);
        end
        @(negedge clk);
        psel = 0; penable = 0; evt_in = '0; evt_during = '0;
    endtask

    task automatic pulse(input logic [NE-1:0] v);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_sys = 0; rst_por = 0;
        @(negedge clk);

        // R1: reset state
        xfer(0, 16'h000, 0, 0, 0, "R1 ctrl reset");
        xfer(0, 16'h004, 0, 0, 0, "R1 err reset");
        xfer(0, 16'h008, 0, 0, 0, "R1 evt reset");
        xfer(0, 16'h00C, 0, 0, 0, "R1 mask reset");

        // R2: control and mask read back; R9 bit 2 reads 0
        xfer(1, 16'h000, 32'h0000_0001, 0, 0, "R2 ctrl write");
        xfer(0, 16'h000, 0, 0, 0, "R2 ctrl read");
        xfer(1, 16'h00C, 32'hFFFF_F5A5, 0, 0, "R2 mask write");
        xfer(0, 16'h00C, 0, 0, 0, "R2 mask read");

        // R10: unmapped in-range offsets
        xfer(1, 16'h010, 32'hFFFF_FFFF, 0, 0, "R10 unmapped write");
        xfer(0, 16'h010, 0, 0, 0, "R10 unmapped read");
        xfer(0, 16'hFFC, 0, 0, 0, "R10 top of window");
        xfer(0, 16'h004, 0, 0, 0, "R10 no error raised");

        // R3/R4: out of range, slave error disabled
        xfer(0, 16'h1000, 0, 0, 0, "R4 oor read no slverr");
        xfer(0, 16'h004, 0, 0, 0, "R3 decode flag");
        xfer(1, 16'h004, 32'h1, 0, 0, "R6 clear decode");
        xfer(0, 16'h004, 0, 0, 0, "R6 decode cleared");

        // R4: enable slave error, oor write must not alias onto mask
        xfer(1, 16'h000, 32'h3, 0, 0, "R4 enable slverr");
        xfer(1, 16'h800C, 32'h0, 0, 0, "R4 oor write slverr");
        xfer(0, 16'h00C, 0, 0, 0, "R3 mask unchanged");
        xfer(0, 16'hF000, 0, 0, 0, "R3 oor read zero");
        xfer(0, 16'h00C, 0, 0, 0, "R4 in range no slverr");
        xfer(1, 16'h004, 32'h3, 0, 0, "R6 clear all errors");

        // R5: parity faults
        xfer(1, 16'h00C, 32'h0000_0003, 1, 0, "R5 bad addr write");
        xfer(0, 16'h00C, 0, 0, 0, "R5 mask kept");
        xfer(0, 16'h004, 0, 0, 0, "R5 parity flag");
        xfer(1, 16'h004, 32'h2, 0, 0, "R6 clear parity");
        xfer(1, 16'h00C, 32'h0000_0007, 0, 1, "R5 bad data write");
        xfer(0, 16'h00C, 0, 0, 0, "R5 mask kept data");
        xfer(0, 16'h00C, 0, 1, 0, "R5 bad addr read zero");
        xfer(0, 16'h004, 0, 0, 0, "R5 parity flag again");
        xfer(1, 16'h004, 32'h3, 0, 0, "R6 clear");

        // R7/R8: events
        xfer(1, 16'h00C, 32'h0, 0, 0, "R8 mask off");
        pulse(11'h008);
        xfer(0, 16'h008, 0, 0, 0, "R7 evt captured");
        xfer(1, 16'h00C, 32'h008, 0, 0, "R8 unmask");
        evt_during = 11'h008;
        xfer(1, 16'h008, 32'h008, 0, 0, "R7 set beats clear");
        xfer(0, 16'h008, 0, 0, 0, "R7 still set");
        xfer(1, 16'h008, 32'h008, 0, 0, "R6 evt clear");
        xfer(0, 16'h008, 0, 0, 0, "R6 evt cleared");
        xfer(1, 16'h00C, 32'h7FF, 0, 0, "R8 mask all");
        for (int i = 0; i < NE; i++) begin
            pulse(NE'(1) << i);
            xfer(0, 16'h008, 0, 0, 0, "R7 each event");
            xfer(1, 16'h008, 32'h7FF, 0, 0, "R6 clear each");
        end
        pulse(11'h401);
        xfer(1, 16'h008, 32'h001, 0, 0, "R6 partial clear");
        xfer(0, 16'h008, 0, 0, 0, "R6 partial left");

        // R9: software reset
        xfer(1, 16'h000, 32'h7, 0, 0, "R9 soft reset write");
        xfer(0, 16'h000, 0, 0, 0, "R9 ctrl cleared");
        xfer(0, 16'h00C, 0, 0, 0, "R9 mask cleared");
        xfer(0, 16'h008, 0, 0, 0, "R9 evt cleared");

        // R1: power-on reset alone
        xfer(1, 16'h000, 32'h3, 0, 0, "R1 setup");
        xfer(1, 16'h00C, 32'h7FF, 0, 0, "R1 setup mask");
        pulse(11'h7FF);
        rst_por = 1;
        @(negedge clk);
        rst_por = 0;
        xfer(0, 16'h000, 0, 0, 0, "R1 por ctrl");
        xfer(0, 16'h00C, 0, 0, 0, "R1 por mask");
        xfer(0, 16'h008, 0, 0, 0, "R1 por evt");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule